// File: doc/BRIEF.md
# Wake Event Status Register Bank

This block records a power-management wake event and turns it into an active-low wake request. It holds two one-bit registers behind a byte-wide, offset-addressed register port: a status bit that latches each rising edge of the event input, and an enable bit that decides whether a latched event is allowed to drive the wake output. Software clears the status bit by writing a one to it. The block has no read strobe; the read data is a combinational function of the address.

The state lives on the standby rail, so only the standby power-on reset (`stby_rst_n`) clears it. The main-rail reset group (main power-on, hard and soft reset) is presented on `main_rst_n`. That input leaves the stored bits alone. While it is asserted, the register port ignores writes, because the host side is held in reset. Events are still latched during a main-rail reset.

A three-state machine follows the stored bits and drives the output. Its states are CLEAR (status 0), HELD (status 1, enable 0) and SIGNAL (status 1, enable 1). Its transitions are:
- CLEAR→HELD: an event while disabled.
- CLEAR→SIGNAL: an event while enabled.
- HELD→SIGNAL: enable set.
- SIGNAL→HELD: enable cleared.
- HELD→CLEAR and SIGNAL→CLEAR: status cleared.

The output is low only in SIGNAL.

Top module: `wake_evt_bank`

## Requirements
- R1: While `stby_rst_n` is low, status and enable read 0 and `wake_n` is 1. After release they stay so until an event or a write.
- R2: A clock edge at which `wake_evt` is 1 after being 0 at the previous edge sets status bit 0, whatever the enable bit holds. The status is visible on the read port after that edge.
- R3: A held-high `wake_evt` sets status only once per rising edge. If status is cleared while the event stays high, status stays 0.
- R4: Writing a value with bit 0 = 1 to offset 0x00 clears status. Writing bit 0 = 0 to offset 0x00 leaves status unchanged.
- R5: Offset 0x02 bit 0 is the enable bit. It is written and read back at that offset.
- R6: `wake_n` is 0 exactly when status and enable were both 1 at the previous clock edge. Otherwise it is 1, so it trails the stored bits by one clock.
- R7: If a rising event and a clearing write to offset 0x00 occur at the same edge, status ends up 1.
- R8: Reads of offsets 0x01, 0x03 and every other offset except 0x00 and 0x02 return 0x00. Bits 7:1 of offsets 0x00 and 0x02 always read 0. Writes to reserved offsets or reserved bits change nothing.
- R9: Asserting `main_rst_n` low does not change status, enable or `wake_n`. Writes made while `main_rst_n` is low are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| stby_rst_n | input | 1 | Standby-rail power-on reset, active low, asynchronous assert |
| main_rst_n | input | 1 | Main-rail reset group, active low; blocks writes only |
| reg_addr | input | 8 | Register offset for reads and writes |
| reg_wr | input | 1 | Write strobe, one write per clock edge |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| wake_evt | input | 1 | Wake event, synchronous to `clk`, edge-detected |
| wake_n | output | 1 | Wake request, active low |

## Verification
A wrong stored bit can be read back at offset 0x00 or 0x02 in the same cycle it goes wrong, because the read path has no register. A state machine that drifts from the stored bits shows on `wake_n` exactly one clock later. The bench therefore checks `wake_n` both at the first and at the second clock after each change: an output that moves too early, too late or not at all fails one of the two samples. Losing state across a main-rail reset shows on the next read once that reset is released.

// File: rtl/wake_evt_pkg.sv
package wake_evt_pkg;

    typedef enum logic [1:0] {
        ST_CLEAR  = 2'b00,
        ST_HELD   = 2'b01,
        ST_SIGNAL = 2'b10
    } wake_state_t;

    localparam int unsigned REG_ADDR_W = 8;
    localparam int unsigned REG_DATA_W = 8;

    localparam logic [REG_ADDR_W-1:0] OFFS_STATUS = 8'h00;
    localparam logic [REG_ADDR_W-1:0] OFFS_ENABLE = 8'h02;

    localparam int unsigned FLAG_BIT = 0;

endpackage

// File: rtl/wake_evt_edge.sv
module wake_evt_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic evt_in,
    output logic evt_rise
);

    logic evt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            evt_q <= 1'b0;
        end else begin
            evt_q <= evt_in;
        end
    end

    assign evt_rise = evt_in & ~evt_q;

endmodule

// File: rtl/wake_evt_regs.sv
module wake_evt_regs
    import wake_evt_pkg::*;
#(
    parameter int unsigned ADDR_W = REG_ADDR_W,
    parameter int unsigned DATA_W = REG_DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              evt_rise,
    output logic              status_o,
    output logic              enable_o,
    output logic [DATA_W-1:0] rdata
);

    localparam int unsigned RSVD_W = DATA_W - 1;

    logic status_q;
    logic enable_q;
    logic hit_status;
    logic hit_enable;
    logic clr_req;

    wire unused_wdata_rsvd = ^wdata[DATA_W-1:FLAG_BIT+1];

    assign hit_status = (addr == ADDR_W'(OFFS_STATUS));
    assign hit_enable = (addr == ADDR_W'(OFFS_ENABLE));
    assign clr_req    = wr_en & hit_status & wdata[FLAG_BIT];

    // An event at the same edge as a clear wins.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status_q <= 1'b0;
        end else if (evt_rise) begin
            status_q <= 1'b1;
        end else if (clr_req) begin
            status_q <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            enable_q <= 1'b0;
        end else if (wr_en && hit_enable) begin
            enable_q <= wdata[FLAG_BIT];
        end
    end

    always_comb begin
        rdata = '0;
        if (hit_status) begin
            rdata = {{RSVD_W{1'b0}}, status_q};
        end else if (hit_enable) begin
            rdata = {{RSVD_W{1'b0}}, enable_q};
        end
    end

    assign status_o = status_q;
    assign enable_o = enable_q;

endmodule

// File: rtl/wake_evt_fsm.sv
module wake_evt_fsm
    import wake_evt_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        status,
    input  logic        enable,
    output wake_state_t state_o,
    output logic        wake_n
);

    wake_state_t state_q;
    wake_state_t state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_CLEAR;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_CLEAR: begin
                if (status && enable) begin
                    state_d = ST_SIGNAL;
                end else if (status) begin
                    state_d = ST_HELD;
                end
            end
            ST_HELD: begin
                if (!status) begin
                    state_d = ST_CLEAR;
                end else if (enable) begin
                    state_d = ST_SIGNAL;
                end
            end
            ST_SIGNAL: begin
                if (!status) begin
                    state_d = ST_CLEAR;
                end else if (!enable) begin
                    state_d = ST_HELD;
                end
            end
            default: state_d = ST_CLEAR;
        endcase
    end

    always_comb begin
        wake_n = 1'b1;
        unique case (state_q)
            ST_SIGNAL: wake_n = 1'b0;
            default:   wake_n = 1'b1;
        endcase
    end

    assign state_o = state_q;

endmodule

// File: rtl/wake_evt_bank.sv
module wake_evt_bank
    import wake_evt_pkg::*;
#(
    parameter int unsigned ADDR_W = REG_ADDR_W,
    parameter int unsigned DATA_W = REG_DATA_W
) (
    input  logic              clk,
    input  logic              stby_rst_n,
    input  logic              main_rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              wake_evt,
    output logic              wake_n
);

    logic        evt_rise;
    logic        wr_ok;
    logic        status;
    logic        enable;
    wake_state_t fsm_state;

    // The host is held in reset while the main rail resets, so its writes are dropped.
    assign wr_ok = reg_wr & main_rst_n;

    wake_evt_edge u_edge (
        .clk      (clk),
        .rst_n    (stby_rst_n),
        .evt_in   (wake_evt),
        .evt_rise (evt_rise)
    );

    wake_evt_regs #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_regs (
        .clk      (clk),
        .rst_n    (stby_rst_n),
        .wr_en    (wr_ok),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .evt_rise (evt_rise),
        .status_o (status),
        .enable_o (enable),
        .rdata    (reg_rdata)
    );

    wake_evt_fsm u_fsm (
        .clk     (clk),
        .rst_n   (stby_rst_n),
        .status  (status),
        .enable  (enable),
        .state_o (fsm_state),
        .wake_n  (wake_n)
    );

endmodule

// File: rtl/wake_evt_bank_chk.sv
module wake_evt_bank_chk
    import wake_evt_pkg::*;
#(
    parameter int unsigned ADDR_W = REG_ADDR_W,
    parameter int unsigned DATA_W = REG_DATA_W
) (
    input logic              clk,
    input logic              stby_rst_n,
    input logic              main_rst_n,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              reg_wr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic [DATA_W-1:0] reg_rdata,
    input logic              wake_evt,
    input logic              wake_n,
    input logic              status,
    input logic              enable,
    input wake_state_t       fsm_state
);

    AST_RESET_IDLE: assert property (@(posedge clk) !stby_rst_n |-> (wake_n && !status && !enable)); // R1

    AST_EVENT_SETS: assert property (@(posedge clk) disable iff (!stby_rst_n)
        $rose(wake_evt) |=> status); // R2

    AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!stby_rst_n)
        (reg_wr && main_rst_n && reg_addr == ADDR_W'(OFFS_STATUS) && reg_wdata[0] && !wake_evt) |=> !status); // R4

    AST_ENABLE_WRITE: assert property (@(posedge clk) disable iff (!stby_rst_n)
        (reg_wr && main_rst_n && reg_addr == ADDR_W'(OFFS_ENABLE)) |=> (enable == $past(reg_wdata[0]))); // R5

    AST_WAKE_TRAILS: assert property (@(posedge clk) disable iff (!stby_rst_n)
        1'b1 |=> (wake_n == !($past(status) && $past(enable)))); // R6

    AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!stby_rst_n)
        ($rose(wake_evt) && reg_wr && reg_addr == ADDR_W'(OFFS_STATUS)) |=> status); // R7

    AST_RSVD_BITS_ZERO: assert property (@(posedge clk) disable iff (!stby_rst_n)
        reg_rdata[DATA_W-1:1] == '0); // R8

    AST_MAIN_RST_HOLD: assert property (@(posedge clk) disable iff (!stby_rst_n)
        (!main_rst_n && !wake_evt) |=> ($stable(enable) && $stable(status))); // R9

    AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (!stby_rst_n)
        $onehot0(fsm_state)); // R6

endmodule

bind wake_evt_bank wake_evt_bank_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk        (clk),
    .stby_rst_n (stby_rst_n),
    .main_rst_n (main_rst_n),
    .reg_addr   (reg_addr),
    .reg_wr     (reg_wr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .wake_evt   (wake_evt),
    .wake_n     (wake_n),
    .status     (status),
    .enable     (enable),
    .fsm_state  (fsm_state)
);

// File: tb/sim_wake_evt_bank.sv
module sim_wake_evt_bank;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG_CYCLES = 20000;

    logic       clk = 1'b0;
    logic       stby_rst_n = 1'b0;
    logic       main_rst_n = 1'b1;
    logic [7:0] reg_addr = 8'h00;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       wake_evt = 1'b0;
    logic       wake_n;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wake_evt_bank u0 (
        .clk        (clk),
        .stby_rst_n (stby_rst_n),
        .main_rst_n (main_rst_n),
        .reg_addr   (reg_addr),
        .reg_wr     (reg_wr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .wake_evt   (wake_evt),
        .wake_n     (wake_n)
    );

    task automatic check(input string req, input int actual, input int expected);
        checks++;
        if (actual != expected) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, actual, expected);
        end
    endtask

    task automatic read_chk(input string req, input logic [7:0] a, input int expected);
        reg_addr = a;
        #1;
        check(req, int'(reg_rdata), expected);
    endtask

    // Drive a one-edge write; returns at the negedge after the write edge.
    task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
        reg_addr  = a;
        reg_wdata = d;
        reg_wr    = 1'b1;
        @(negedge clk);
        reg_wr    = 1'b0;
        reg_wdata = 8'h00;
    endtask

    task automatic pulse_event();
        wake_evt = 1'b1;
        @(negedge clk);
        wake_evt = 1'b0;
    endtask

    task automatic t_reset();
        read_chk("R1 status after reset", 8'h00, 0);
        read_chk("R1 enable after reset", 8'h02, 0);
        check("R1 wake_n after reset", int'(wake_n), 1);
    endtask

    task automatic t_event_disabled();
        pulse_event();
        read_chk("R2 status set while disabled", 8'h00, 1);
        @(negedge clk);
        check("R6 wake_n stays high while disabled", int'(wake_n), 1);
        bus_write(8'h00, 8'h00);
        read_chk("R4 write 0 keeps status", 8'h00, 1);
        bus_write(8'h00, 8'h01);
        read_chk("R4 write 1 clears status", 8'h00, 0);
    endtask

    task automatic t_enable_wake();
        bus_write(8'h02, 8'hFF);
        read_chk("R5 enable reads 1", 8'h02, 1);
        pulse_event();
        check("R6 wake_n one clock after status", int'(wake_n), 1);
        @(negedge clk);
        check("R6 wake_n asserted", int'(wake_n), 0);
        bus_write(8'h00, 8'h01);
        check("R6 wake_n trails clear by one clock", int'(wake_n), 0);
        @(negedge clk);
        check("R6 wake_n released after clear", int'(wake_n), 1);
    endtask

    task automatic t_held_event();
        wake_evt = 1'b1;
        @(negedge clk);
        read_chk("R3 held event sets status", 8'h00, 1);
        bus_write(8'h00, 8'h01);
        repeat (3) @(negedge clk);
        read_chk("R3 held event does not set again", 8'h00, 0);
        wake_evt = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_same_edge();
        reg_addr  = 8'h00;
        reg_wdata = 8'h01;
        reg_wr    = 1'b1;
        wake_evt  = 1'b1;
        @(negedge clk);
        reg_wr   = 1'b0;
        wake_evt = 1'b0;
        read_chk("R7 event wins over clear", 8'h00, 1);
        bus_write(8'h00, 8'h01);
        @(negedge clk);
    endtask

    task automatic t_reserved();
        bus_write(8'h01, 8'hFF);
        bus_write(8'h03, 8'hFF);
        bus_write(8'h40, 8'hFF);
        read_chk("R8 offset 0x01 reads zero", 8'h01, 0);
        read_chk("R8 offset 0x03 reads zero", 8'h03, 0);
        read_chk("R8 offset 0x40 reads zero", 8'h40, 0);
        read_chk("R8 status untouched by reserved writes", 8'h00, 0);
        bus_write(8'h02, 8'hFE);
        read_chk("R8 reserved bits ignored on enable", 8'h02, 0);
        bus_write(8'h02, 8'h01);
        read_chk("R8 enable bits 7:1 read zero", 8'h02, 1);
    endtask

    task automatic t_main_reset();
        pulse_event();
        @(negedge clk);
        check("R9 wake_n low before main reset", int'(wake_n), 0);
        main_rst_n = 1'b0;
        bus_write(8'h00, 8'h01);
        bus_write(8'h02, 8'h00);
        repeat (2) @(negedge clk);
        check("R9 wake_n held through main reset", int'(wake_n), 0);
        main_rst_n = 1'b1;
        @(negedge clk);
        read_chk("R9 status kept", 8'h00, 1);
        read_chk("R9 enable kept", 8'h02, 1);
    endtask

    task automatic t_standby_reset();
        stby_rst_n = 1'b0;
        #1;
        check("R1 wake_n high in standby reset", int'(wake_n), 1);
        @(negedge clk);
        stby_rst_n = 1'b1;
        @(negedge clk);
        read_chk("R1 status cleared by standby reset", 8'h00, 0);
        read_chk("R1 enable cleared by standby reset", 8'h02, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        stby_rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_event_disabled();
        t_enable_wake();
        t_held_event();
        t_same_edge();
        t_reserved();
        t_main_reset();
        t_standby_reset();
        done = 1'b1;
    end

    initial begin
        int n = 0;
        while (!done && n < WATCHDOG_CYCLES) begin
            @(posedge clk);
            n++;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", n, 0);
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule